// File: doc/BRIEF.md
# I2C Host Transaction Engine

This block is a register-programmed I2C master. Software programs a target address, a sub-address, a transfer length and, for writes, the payload bytes in a byte FIFO. A single start command then runs the whole bus transaction without further intervention. Three transaction shapes exist: a sub-addressed write, a current-address read, and a sequential read that sends the sub-address, issues a repeated START and then reads.

Bus timing is not handled here. The engine issues one bit-level operation at a time (START, STOP, write one bit, read one bit) to a separate SCL/SDA timing generator and waits for that generator to report completion. The engine checks each acknowledge slot, records where a NACK happened, stores received bytes in the same FIFO, and raises an interrupt on completion when enabled.

Top module: `i2c_txn_engine`

## Requirements
- R1: A register write to offset 0 loads enable (bit 0), interrupt enable (bit 1) and command code (bits 4:2). A transaction starts only if that write has bit 5 and bit 0 both set, the engine is idle, and the code is 000 (write), 010 (current-address read) or 100 (sequential read). Any other start request has no effect on the bus.
- R2: A write sends START, the address byte {target[6:0],0}, the sub-address byte, then `length` bytes popped from the FIFO in order, then STOP. Every byte is sent MSB first and is followed by one read bit that carries the acknowledge.
- R3: A current-address read sends START and {target,1}, receives `length` bytes MSB first into the FIFO, then sends STOP. After each received byte it writes an acknowledge bit: 0 after every byte except the last, and 1 after the last.
- R4: A sequential read sends START, {target,0}, the sub-address, a second START, {target,1}, then receives data as in R3, then STOP.
- R5: A NACK on any address byte sets status bit 1 and is followed at once by STOP.
- R6: A NACK on a transmitted byte that is neither an address byte nor the last byte of the transaction sets status bit 0 and is followed at once by STOP. A NACK on the last byte of a write is ignored.
- R7: Status bit 2 sets when the final STOP completes, and status bit 3 reads 1 while a transaction runs. Status bits 0 to 2 hold until a 1 is written to them at offset 1. Output `irq` equals interrupt enable AND status bit 2.
- R8: The FIFO status register at offset 7 has these bits: bit 0 overrun (a push while full; the byte is dropped), bit 1 underrun (a pop while empty), bit 2 full, bit 3 empty. Bits 0 and 1 hold until a write of bit 0 to offset 6 (flush), which empties the FIFO and clears them. Data is pushed and popped at offset 4.
- R9: `phy_req` is a single-cycle pulse. No new request is issued until `phy_done` has answered the previous one.
- R10: Bit 8 of the target register (offset 2; target address in bits 7:1) is copied to `aux_out` each time an address byte is issued.
- R11: The length register (offset 5, 6 bits) sets the number of data bytes. For reads, a length of 0 behaves as 1. A write with length 0 sends only the sub-address, and that byte then counts as the last byte.
- R12: Status bit 4 reads 1 while either FIFO error flag (overrun or underrun) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at offset 4) |
| reg_wdata | input | 9 | Register write data |
| reg_rdata | output | 9 | Register read data for `reg_addr` |
| irq | output | 1 | Completion interrupt |
| aux_out | output | 1 | Auxiliary level latched at each address byte |
| phy_req | output | 1 | Bit-operation request pulse |
| phy_op | output | 2 | 0 START, 1 STOP, 2 write bit, 3 read bit |
| phy_wbit | output | 1 | Bit value for a write operation |
| phy_done | input | 1 | Timing generator finished the last operation |
| phy_rbit | input | 1 | Bit sampled by a read operation |

## Verification
The bench sweeps the write length from 0 to 4 and the read length from 0 to 3, and checks every bus byte and acknowledge bit against a slave model. An off-by-one in the byte count would show up there as a byte too many or too few. A NACK is injected on each byte position in turn. A design that mixed up address, middle and last positions would set the wrong status bit, or would keep transmitting after a NACK that should have aborted. A sequential read that skipped the repeated START would show one START instead of two and would read with the wrong direction bit. The FIFO is pushed past full and read while empty, to show that the sticky flags hold and that a flush clears them.

// File: rtl/i2c_txn_pkg.sv
package i2c_txn_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bit_op_e;

  localparam logic [2:0] CMD_WR  = 3'b000;
  localparam logic [2:0] CMD_CUR = 3'b010;
  localparam logic [2:0] CMD_SEQ = 3'b100;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_STAT  = 3'd1;
  localparam logic [2:0] RA_TGT   = 3'd2;
  localparam logic [2:0] RA_SUB   = 3'd3;
  localparam logic [2:0] RA_FDATA = 3'd4;
  localparam logic [2:0] RA_LEN   = 3'd5;
  localparam logic [2:0] RA_FCTL  = 3'd6;
  localparam logic [2:0] RA_FSTAT = 3'd7;

  function automatic logic cmd_known(input logic [2:0] c);
    return (c == CMD_WR) || (c == CMD_CUR) || (c == CMD_SEQ);
  endfunction

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction
endpackage

// File: rtl/i2c_txn_fifo.sv
module i2c_txn_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [WIDTH-1:0]             wdata,
  input  logic                         pop,
  output logic [WIDTH-1:0]             head,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [LW-1:0]    cnt_q;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == LW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign level   = cnt_q;
  assign head    = mem[rp_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= bump(wp_q);
      if (do_pop)  rp_q <= bump(rp_q);
      cnt_q <= cnt_q + LW'(do_push) - LW'(do_pop);
    end
  end
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_txn_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [2:0]    cmd,
  input  logic [6:0]    tgt,
  input  logic [7:0]    sub,
  input  logic [LW-1:0] len,
  input  logic [7:0]    fifo_head,
  input  logic          fifo_empty,
  output logic          fifo_pop,
  output logic          fifo_push,
  output logic [7:0]    fifo_wdata,
  output logic          phy_req,
  output logic [1:0]    phy_op,
  output logic          phy_wbit,
  input  logic          phy_done,
  input  logic          phy_rbit,
  output logic          busy,
  output logic          ev_fin,
  output logic          ev_addr_issue,
  output logic          ev_addr_nack,
  output logic          ev_mid_nack
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_e;
  typedef enum logic [2:0] {PH_AW, PH_SUB, PH_DW, PH_AR, PH_DR} ph_e;

  st_e           st_q;
  ph_e           ph_q;
  logic          wait_q;
  logic [7:0]    sh_q;
  logic [3:0]    bit_q;
  logic [LW-1:0] cnt_q, len_q;
  logic [2:0]    cmd_q;

  logic          is_rd, tx, is_addr, last_data, last_byte;
  logic          step, ack_step, adv;
  logic [LW-1:0] tot;
  logic [7:0]    data_next;
  bit_op_e       op;

  function automatic logic [LW-1:0] eff_len(input logic [LW-1:0] n, input logic rd);
    return (rd && n == '0) ? LW'(1) : n;
  endfunction

  always_comb begin
    is_rd     = (cmd_q != CMD_WR);
    tx        = (ph_q != PH_DR);
    is_addr   = (ph_q == PH_AW) || (ph_q == PH_AR);
    tot       = eff_len(len_q, is_rd);
    last_data = (({1'b0, cnt_q} + 1'b1) == {1'b0, tot});
    last_byte = (((ph_q == PH_DW) || (ph_q == PH_DR)) && last_data) ||
                ((ph_q == PH_SUB) && !is_rd && (tot == '0));
    step         = wait_q && phy_done;
    ack_step     = step && (st_q == S_BIT) && (bit_q == 4'd8);
    ev_addr_nack = ack_step && tx && phy_rbit && is_addr;
    ev_mid_nack  = ack_step && tx && phy_rbit && !is_addr && !last_byte;
    adv          = ack_step && !ev_addr_nack && !ev_mid_nack;
    fifo_pop     = adv && (((ph_q == PH_SUB) && !is_rd && (tot != '0)) ||
                           ((ph_q == PH_DW) && !last_data));
    fifo_push    = adv && (ph_q == PH_DR);
    fifo_wdata   = sh_q;
    data_next    = fifo_empty ? 8'h00 : fifo_head;
    ev_fin        = step && (st_q == S_STOP);
    ev_addr_issue = step && (st_q == S_START);
    busy          = (st_q != S_IDLE);
    phy_req       = busy && !wait_q;

    op       = OP_READ;
    phy_wbit = 1'b1;
    case (st_q)
      S_START: op = OP_START;
      S_STOP:  op = OP_STOP;
      S_BIT: begin
        if (bit_q != 4'd8) begin
          op       = tx ? OP_WRITE : OP_READ;
          phy_wbit = tx ? sh_q[7] : 1'b1;
        end else begin
          op       = tx ? OP_READ : OP_WRITE;
          phy_wbit = tx ? 1'b1 : last_byte;
        end
      end
      default: op = OP_READ;
    endcase
    phy_op = op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ph_q   <= PH_AW;
      wait_q <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      cmd_q  <= CMD_WR;
    end else begin
      if (phy_req) wait_q <= 1'b1;
      if (step)    wait_q <= 1'b0;
      if (go) begin
        st_q  <= S_START;
        ph_q  <= (cmd == CMD_CUR) ? PH_AR : PH_AW;
        cmd_q <= cmd;
        len_q <= len;
        cnt_q <= '0;
      end else if (step) begin
        case (st_q)
          S_START: begin
            st_q  <= S_BIT;
            bit_q <= '0;
            sh_q  <= addr_byte(tgt, ph_q == PH_AR);
          end
          S_BIT: begin
            if (bit_q != 4'd8) begin
              bit_q <= bit_q + 1'b1;
              sh_q  <= {sh_q[6:0], tx ? 1'b0 : phy_rbit};
            end else if (!adv) begin
              st_q <= S_STOP;
            end else begin
              bit_q <= '0;
              case (ph_q)
                PH_AW: begin ph_q <= PH_SUB; sh_q <= sub; end
                PH_SUB: begin
                  if (cmd_q == CMD_SEQ) begin ph_q <= PH_AR; st_q <= S_START; end
                  else if (tot == '0) st_q <= S_STOP;
                  else begin ph_q <= PH_DW; sh_q <= data_next; end
                end
                PH_AR: ph_q <= PH_DR;
                PH_DW: begin
                  cnt_q <= cnt_q + 1'b1;
                  if (last_data) st_q <= S_STOP;
                  else sh_q <= data_next;
                end
                PH_DR: begin
                  cnt_q <= cnt_q + 1'b1;
                  if (last_data) st_q <= S_STOP;
                end
                default: st_q <= S_STOP;
              endcase
            end
          end
          S_STOP:  st_q <= S_IDLE;
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_txn_engine.sv
module i2c_txn_engine
  import i2c_txn_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int REG_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  output logic             aux_out,
  output logic             phy_req,
  output logic [1:0]       phy_op,
  output logic             phy_wbit,
  input  logic             phy_done,
  input  logic             phy_rbit
);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);

  logic             en_q, ie_q, aux_lvl_q, aux_q;
  logic [2:0]       cmd_q;
  logic [6:0]       tgt_q;
  logic [7:0]       sub_q;
  logic [CNT_W-1:0] len_q;
  logic             st_db, st_dne, st_done, f_ovr, f_udr;

  logic wr_ctrl, wr_stat, sw_push, sw_pop, flush, ev_go;
  logic eng_push, eng_pop, f_push, f_pop, f_full, f_empty;
  logic busy, ev_fin, ev_addr_issue, ev_addr_nack, ev_mid_nack;
  logic [7:0]       eng_data, f_din, f_head;
  logic [CNT_W-1:0] f_level;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign sw_push = reg_wr && (reg_addr == RA_FDATA);
  assign sw_pop  = reg_rd && (reg_addr == RA_FDATA);
  assign flush   = reg_wr && (reg_addr == RA_FCTL) && reg_wdata[0];
  assign ev_go   = wr_ctrl && reg_wdata[5] && reg_wdata[0] && !busy &&
                   cmd_known(reg_wdata[4:2]);
  assign f_push  = eng_push || sw_push;
  assign f_pop   = eng_pop || sw_pop;
  assign f_din   = eng_push ? eng_data : reg_wdata[7:0];

  i2c_txn_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(f_push), .wdata(f_din),
    .pop(f_pop), .head(f_head), .full(f_full), .empty(f_empty), .level(f_level)
  );

  i2c_txn_seq #(.LW(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(ev_go), .cmd(reg_wdata[4:2]), .tgt(tgt_q),
    .sub(sub_q), .len(len_q), .fifo_head(f_head), .fifo_empty(f_empty),
    .fifo_pop(eng_pop), .fifo_push(eng_push), .fifo_wdata(eng_data),
    .phy_req(phy_req), .phy_op(phy_op), .phy_wbit(phy_wbit),
    .phy_done(phy_done), .phy_rbit(phy_rbit), .busy(busy), .ev_fin(ev_fin),
    .ev_addr_issue(ev_addr_issue), .ev_addr_nack(ev_addr_nack),
    .ev_mid_nack(ev_mid_nack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ie_q <= 1'b0; cmd_q <= '0;
      tgt_q <= '0; aux_lvl_q <= 1'b0; sub_q <= '0; len_q <= '0;
      st_db <= 1'b0; st_dne <= 1'b0; st_done <= 1'b0;
      f_ovr <= 1'b0; f_udr <= 1'b0; aux_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[0];
        ie_q  <= reg_wdata[1];
        cmd_q <= reg_wdata[4:2];
      end
      if (reg_wr && reg_addr == RA_TGT) begin
        tgt_q     <= reg_wdata[7:1];
        aux_lvl_q <= reg_wdata[8];
      end
      if (reg_wr && reg_addr == RA_SUB) sub_q <= reg_wdata[7:0];
      if (reg_wr && reg_addr == RA_LEN) len_q <= reg_wdata[CNT_W-1:0];

      if (ev_mid_nack) st_db <= 1'b1;
      else if (wr_stat && reg_wdata[0]) st_db <= 1'b0;
      if (ev_addr_nack) st_dne <= 1'b1;
      else if (wr_stat && reg_wdata[1]) st_dne <= 1'b0;
      if (ev_fin) st_done <= 1'b1;
      else if (wr_stat && reg_wdata[2]) st_done <= 1'b0;

      if (flush) begin
        f_ovr <= 1'b0;
        f_udr <= 1'b0;
      end else begin
        if (f_push && f_full)  f_ovr <= 1'b1;
        if (f_pop  && f_empty) f_udr <= 1'b1;
      end

      if (ev_addr_issue) aux_q <= aux_lvl_q;
    end
  end

  assign irq     = ie_q && st_done;
  assign aux_out = aux_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:  reg_rdata[4:0] = {cmd_q, ie_q, en_q};
      RA_STAT:  reg_rdata[4:0] = {f_ovr || f_udr, busy, st_done, st_dne, st_db};
      RA_TGT:   reg_rdata[8:0] = {aux_lvl_q, tgt_q, 1'b0};
      RA_SUB:   reg_rdata[7:0] = sub_q;
      RA_FDATA: reg_rdata[7:0] = f_empty ? 8'h00 : f_head;
      RA_LEN:   reg_rdata[CNT_W-1:0] = len_q;
      RA_FSTAT: reg_rdata[3:0] = {f_empty, f_full, f_udr, f_ovr};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_txn_engine_chk.sv
module i2c_txn_engine_chk #(
  parameter int FIFO_DEPTH = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           phy_req,
  input logic                           busy,
  input logic                           ev_go,
  input logic                           ev_fin,
  input logic                           ev_addr_nack,
  input logic                           ev_mid_nack,
  input logic                           st_done,
  input logic                           st_dne,
  input logic                           st_db,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] f_level
);
  // R9: one request pulse, then silence until answered
  a_r9_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req |=> !phy_req);
  // R9: requests only come from a running transaction
  a_r9_req_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req |-> busy);
  // R1: an accepted start makes the engine busy
  a_r1_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_go |=> busy);
  // R7: the final STOP leaves the engine idle with completion set
  a_r7_fin_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fin |=> (st_done && !busy));
  // R5: an address NACK is recorded
  a_r5_addr_nack: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_nack |=> st_dne);
  // R6: a middle-byte NACK is recorded
  a_r6_mid_nack: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mid_nack |=> st_db);
  // R8: occupancy never passes the depth
  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    f_level <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));
endmodule

bind i2c_txn_engine i2c_txn_engine_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .phy_req(phy_req), .busy(busy), .ev_go(ev_go),
  .ev_fin(ev_fin), .ev_addr_nack(ev_addr_nack), .ev_mid_nack(ev_mid_nack),
  .st_done(st_done), .st_dne(st_dne), .st_db(st_db), .f_level(f_level)
);

// File: tb/i2c_txn_engine_tb.sv
module i2c_txn_engine_tb;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_TGT = 3'd2, A_SUB = 3'd3;
  localparam logic [2:0] A_FD = 3'd4, A_LEN = 3'd5, A_FC = 3'd6, A_FS = 3'd7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [2:0] ra = '0;
  logic       rwr = 1'b0, rrd = 1'b0;
  logic [8:0] wd = '0;
  wire  [8:0] rdat;
  wire        irq, aux, preq, pwb;
  wire  [1:0] pop;
  logic       pdone = 1'b0, prb = 1'b1;

  i2c_txn_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(ra), .reg_wr(rwr), .reg_rd(rrd),
    .reg_wdata(wd), .reg_rdata(rdat), .irq(irq), .aux_out(aux),
    .phy_req(preq), .phy_op(pop), .phy_wbit(pwb), .phy_done(pdone), .phy_rbit(prb)
  );

  int checks = 0, errors = 0;
  int nb = 0, bi = 0, dly = 0, n_start = 0, n_stop = 0, proto_err = 0;
  logic [7:0]  sh = '0, pb;
  logic        dir_rd = 1'b0, exp_addr = 1'b0, rb_pend = 1'b1;
  logic [7:0]  wr_log [16];
  logic        ack_log [16];
  logic [15:0] nack_mask = '0;

  function automatic logic [7:0] pat(input int i);
    return 8'(165 ^ ((i * 29) & 255));
  endfunction

  // Slave and timing-generator model
  always @(negedge clk) begin
    pdone = 1'b0;
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin pdone = 1'b1; prb = rb_pend; end
    end
    if (preq) begin
      rb_pend = 1'b1;
      if (pop == 2'd0) begin n_start++; bi = 0; exp_addr = 1'b1; dir_rd = 1'b0; end
      else if (pop == 2'd1) begin n_stop++; bi = 0; end
      else if (bi < 8) begin
        if (dir_rd && !exp_addr) begin
          if (pop != 2'd3) proto_err++;
          pb = pat(nb);
          rb_pend = pb[7-bi];
        end else begin
          if (pop != 2'd2) proto_err++;
          sh = {sh[6:0], pwb};
        end
        bi++;
      end else begin
        if (dir_rd && !exp_addr) begin
          if (pop != 2'd2) proto_err++;
          if (nb < 16) ack_log[nb] = pwb;
        end else begin
          if (pop != 2'd3) proto_err++;
          if (nb < 16) begin rb_pend = nack_mask[nb]; wr_log[nb] = sh; end
          if (exp_addr) begin dir_rd = sh[0]; exp_addr = 1'b0; end
        end
        bi = 0;
        nb++;
      end
      dly = 2;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [8:0] d);
    @(negedge clk); ra = a; wd = d; rwr = 1'b1;
    @(negedge clk); rwr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [8:0] d);
    @(negedge clk); ra = a; rrd = 1'b1; #1 d = rdat;
    @(negedge clk); rrd = 1'b0;
  endtask

  task automatic run(input logic [8:0] ctrl, output logic [8:0] st);
    logic [8:0] s;
    nb = 0; n_start = 0; n_stop = 0; proto_err = 0;
    wreg(A_CTRL, ctrl);
    rreg(A_STAT, s);
    check("R7 busy while running", 32'(s[3]), 1);
    for (int i = 0; i < 3000 && s[3]; i++) rreg(A_STAT, s);
    st = s;
    check("R9 bit op order", 32'(proto_err), 0);
  endtask

  task automatic clr();
    wreg(A_STAT, 9'h007);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] s, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rreg(A_STAT, s);  check("R7 reset status", 32'(s), 0);
    rreg(A_FS, s);    check("R8 reset fifo empty", 32'(s), 32'h8);
    check("R7 reset irq", 32'(irq), 0);

    wreg(A_TGT, 9'h0A0); wreg(A_SUB, 9'h012);

    // R2/R11: write length sweep
    for (int n = 0; n <= 4; n++) begin
      nack_mask = '0;
      for (int k = 0; k < n; k++) wreg(A_FD, 9'(8'h40 + k + n*8));
      wreg(A_LEN, 9'(n));
      run(9'h023, s);
      check("R7 done status", 32'(s), 32'h4);
      check("R7 irq follows done", 32'(irq), 1);
      check("R2 byte count", 32'(nb), 32'(2+n));
      check("R2 addr byte", 32'(wr_log[0]), 32'hA0);
      check("R2 sub byte", 32'(wr_log[1]), 32'h12);
      for (int k = 0; k < n; k++) check("R2 data byte", 32'(wr_log[2+k]), 32'(8'(8'h40 + k + n*8)));
      check("R2 start stop", 32'({n_start, n_stop}), 32'({32'd1, 32'd1}));
      rreg(A_FS, s); check("R2 fifo drained", 32'(s), 32'h8);
      clr();
      check("R7 irq cleared", 32'(irq), 0);
    end

    // R6: last write byte NACK ignored, middle NACK aborts
    for (int k = 0; k < 3; k++) wreg(A_FD, 9'(k));
    wreg(A_LEN, 9'd3);
    nack_mask = 16'h0010;
    run(9'h023, s);
    check("R6 last nack ignored", 32'(s), 32'h4);
    check("R6 last nack all bytes", 32'(nb), 5);
    clr();
    for (int k = 0; k < 3; k++) wreg(A_FD, 9'(k));
    nack_mask = 16'h0004;
    run(9'h023, s);
    check("R6 middle nack flag", 32'(s), 32'h5);
    check("R6 stop after nacked byte", 32'(nb), 3);
    check("R6 stop issued", 32'(n_stop), 1);
    wreg(A_FC, 9'h001); clr();

    // R5: address NACK
    nack_mask = 16'h0001;
    run(9'h023, s);
    check("R5 addr nack flag", 32'(s), 32'h6);
    check("R5 stop after address", 32'(nb), 1);
    wreg(A_FC, 9'h001); clr();
    nack_mask = '0;

    // R3/R11: current-address read length sweep
    for (int n = 0; n <= 3; n++) begin
      int m;
      m = (n == 0) ? 1 : n;
      wreg(A_LEN, 9'(n));
      run(9'h02B, s);
      check("R3 done", 32'(s), 32'h4);
      check("R3 addr byte", 32'(wr_log[0]), 32'hA1);
      check("R11 read byte count", 32'(nb), 32'(1+m));
      for (int k = 1; k <= m; k++) begin
        rreg(A_FD, d);
        check("R3 read data", 32'(d[7:0]), 32'(pat(k)));
        check("R3 master ack", 32'(ack_log[k]), 32'(k == m));
      end
      clr();
    end

    // R4: sequential read
    wreg(A_LEN, 9'd2);
    run(9'h033, s);
    check("R4 done", 32'(s), 32'h4);
    check("R4 two starts", 32'(n_start), 2);
    check("R4 bytes", 32'({wr_log[0], wr_log[1], wr_log[2]}), 32'h00A012A1);
    for (int k = 3; k <= 4; k++) begin
      rreg(A_FD, d);
      check("R4 read data", 32'(d[7:0]), 32'(pat(k)));
      check("R4 master ack", 32'(ack_log[k]), 32'(k == 4));
    end
    clr();
    nack_mask = 16'h0004;
    run(9'h033, s);
    check("R5 repeated addr nack", 32'(s), 32'h6);
    clr();
    nack_mask = 16'h0002;
    run(9'h033, s);
    check("R6 sub nack in seq read", 32'(s), 32'h5);
    clr(); nack_mask = '0;
    wreg(A_FC, 9'h001);

    // R8/R12: FIFO flags
    for (int k = 0; k < 33; k++) wreg(A_FD, 9'(k));
    rreg(A_FS, s); check("R8 overrun and full", 32'(s), 32'h5);
    rreg(A_STAT, s); check("R12 fifo error status", 32'(s), 32'h10);
    rreg(A_FD, d); check("R8 first byte kept", 32'(d[7:0]), 0);
    wreg(A_FC, 9'h001);
    rreg(A_FS, s); check("R8 flush clears", 32'(s), 32'h8);
    rreg(A_FD, d);
    rreg(A_FS, s); check("R8 underrun", 32'(s), 32'hA);
    rreg(A_STAT, s); check("R12 underrun status", 32'(s), 32'h10);
    wreg(A_FC, 9'h001);
    rreg(A_STAT, s); check("R12 cleared by flush", 32'(s), 0);

    // R1: ignored starts
    n_start = 0;
    wreg(A_CTRL, 9'h022);
    wreg(A_CTRL, 9'h027);
    repeat (20) @(negedge clk);
    rreg(A_STAT, s);
    check("R1 ignored start idle", 32'(s), 0);
    check("R1 no bus activity", 32'(n_start), 0);

    // R10 and R7 with interrupt disabled
    wreg(A_LEN, 9'd0);
    wreg(A_TGT, 9'h1A0);
    run(9'h021, s);
    check("R10 aux high", 32'(aux), 1);
    check("R7 irq masked", 32'(irq), 0);
    check("R7 done with irq masked", 32'(s), 32'h4);
    clr();
    wreg(A_TGT, 9'h0A0);
    run(9'h021, s);
    check("R10 aux low", 32'(aux), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule